// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire bus and drives the open-drain clock and data lines so that a target left stuck in the middle of a transfer is put back into a known protocol state. A single-cycle request starts a fixed sequence. The sequence issues a start condition and then nine clock pulses with the data line released, so that a target still shifting out a byte can finish it. It then issues a second start, a stop, and a wait for the bus-free time.

Every interval in the sequence comes from an input count in system-clock cycles. These counts cover the clock low and high half-periods, the setup and hold of the start and stop conditions, and the bus-free time. The block reports that it is running through a busy level and that it has finished through a one-cycle done pulse. Each line output means "pull the line low" when it is 1, and "released" when it is 0.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, and while idle, scl_oe and sda_oe are 0 (both lines released), busy is 0 and done is 0.
- R2: On kick, both lines stay released for setup_cnt cycles. sda_oe then rises while SCL stays released, and SDA stays low with SCL released for hold_cnt cycles before scl_oe first rises.
- R3: Exactly nine SCL low pulses follow. Each lasts low_cnt cycles, and each released period between two pulses lasts high_cnt cycles.
- R4: SDA is released in the second cycle of the first SCL low pulse and stays released through all nine clocks. During the clocks, SDA changes only while SCL is low.
- R5: After the ninth pulse, SCL stays released and SDA stays released for high_cnt plus setup_cnt cycles. SDA then falls with SCL released, giving the second start. SDA stays low for hold_cnt plus setup_cnt cycles and then rises with SCL released, giving the stop.
- R6: After the stop, busy stays 1 for free_cnt more cycles. In the next cycle busy is 0 and done is 1 for exactly one cycle. busy is 1 for setup+hold+9*(low+high)+setup+hold+setup+free cycles in total.
- R7: kick has no effect while busy is 1. The sequence length, the edge counts and the single done pulse are unchanged, and the block is idle after done.
- R8: A count of 0 on high_cnt, setup_cnt, hold_cnt or free_cnt gives an interval of one cycle.
- R9: scl_oe and sda_oe never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| kick | input | 1 | Starts a recovery sequence when idle |
| low_cnt | input | CW | SCL low half-period in cycles (at least 2) |
| high_cnt | input | CW | SCL high half-period in cycles |
| setup_cnt | input | CW | Start/stop setup time in cycles |
| hold_cnt | input | CW | Start hold time in cycles |
| free_cnt | input | CW | Bus-free time after the stop, in cycles |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The assertions assume that all five counts stay constant while busy is 1. They also assume that low_cnt is at least 2, so that releasing SDA inside the first low pulse does not coincide with an SCL edge. The stimulus changes counts only when the block is idle, and it draws low_cnt from 2 upward. The other counts are drawn from 0 upward so that zero values are exercised. Mid-sequence kick pulses are placed at fixed cycle offsets that always fall inside a sequence.

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int CW   = 16,
  parameter int NCLK = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic [CW-1:0] setup_cnt,
  input  logic [CW-1:0] hold_cnt,
  input  logic [CW-1:0] free_cnt,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done
);
  localparam int PW = $clog2(NCLK + 1);
  localparam logic [PW-1:0] LASTP = PW'(NCLK - 1);

  typedef enum logic [3:0] {
    IDLE, S1SU, S1HD, CLO, CHI, RSU, RHD, PSU, FREE
  } st_t;

  st_t           st;
  logic [CW-1:0] tmr, lim;
  logic [PW-1:0] pcnt;
  logic          last;

  always_comb begin
    case (st)
      CLO:             lim = low_cnt;
      CHI:             lim = high_cnt;
      S1SU, RSU, PSU:  lim = setup_cnt;
      S1HD, RHD:       lim = hold_cnt;
      FREE:            lim = free_cnt;
      default:         lim = '0;
    endcase
  end

  assign last   = ({1'b0, tmr} + 1'b1) >= {1'b0, lim};
  assign busy   = st != IDLE;
  assign scl_oe = st == CLO;
  assign sda_oe = st == S1HD || st == RHD || st == PSU ||
                  (st == CLO && pcnt == '0 && tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      tmr  <= '0;
      pcnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        tmr  <= '0;
        pcnt <= '0;
        if (kick) st <= S1SU;
      end else if (last) begin
        tmr <= '0;
        case (st)
          S1SU: st <= S1HD;
          S1HD: st <= CLO;
          CLO:  st <= CHI;
          CHI: begin
            pcnt <= pcnt + 1'b1;
            st   <= (pcnt == LASTP) ? RSU : CLO;
          end
          RSU:  st <= RHD;
          RHD:  st <= PSU;
          PSU:  st <= FREE;
          FREE: begin
            st   <= IDLE;
            done <= 1'b1;
          end
          default: st <= IDLE;
        endcase
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  // R9
  no_dual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R3
  pulse_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PW'(NCLK));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kick && st != S1SU) |=> st != S1SU);

  // R4
  sda_free_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CHI) |-> !sda_oe);
endmodule

// File: tb/i2c_bus_recover_bench.sv
module i2c_bus_recover_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, kick = 0;
  logic [15:0] low_cnt = 2, high_cnt = 1, setup_cnt = 1, hold_cnt = 1, free_cnt = 1;
  logic        scl_oe, sda_oe, busy, done;
  int          checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_bus_recover u_i2c_bus_recover (
    .clk(clk), .rst_n(rst_n), .kick(kick),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .setup_cnt(setup_cnt),
    .hold_cnt(hold_cnt), .free_cnt(free_cnt),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done));

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int L, input int Hi, input int S, input int H,
                         input int F, input bit rekick);
    int n = 0, busy_n = 0, rises = 0, falls = 0, lowrun = 0, highrun = 0;
    int bad_low = 0, bad_high = 0, first_high = -1, hold1 = 0, sdalow_scllow = 0;
    int lowchg = 0, same_chg = 0, sfall = 0, srise = 0, tail_high = 0, mid = 0;
    int free_n = 0, busy_at_done = 1;
    bit got_done = 0, ps = 1, pd = 1, s, d;
    int el = eff(L), eh = eff(Hi), es = eff(S), ed = eff(H), ef = eff(F);
    int total = es + ed + 9*(el + eh) + es + ed + es + ef;
    @(negedge clk);
    low_cnt = 16'(L); high_cnt = 16'(Hi); setup_cnt = 16'(S);
    hold_cnt = 16'(H); free_cnt = 16'(F);
    kick = 1;
    @(negedge clk);
    kick = 0;
    while (n < 20000) begin
      s = !scl_oe; d = !sda_oe;
      if (done) begin got_done = 1; busy_at_done = busy; break; end
      if (busy) busy_n++;
      if (s != ps && d != pd) same_chg++;
      if (d != pd && !(s && ps)) lowchg++;
      if (pd && !d && s && ps) sfall++;
      if (!pd && d && s && ps) srise++;
      if (ps && !s) begin
        falls++;
        if (falls == 1) first_high = highrun;
        else if (highrun != eh) bad_high++;
        lowrun = 0;
      end
      if (!ps && s) begin
        rises++;
        if (lowrun != el) bad_low++;
        highrun = 0;
      end
      if (!s) lowrun++; else highrun++;
      if (s && !d && falls == 0) hold1++;
      if (!s && !d) sdalow_scllow++;
      if (rises == 9 && s && d && srise == 0) tail_high++;
      if (rises == 9 && s && !d) mid++;
      if (busy && srise == 1 && d) free_n++;
      kick = rekick && (n == 3 || n == 25);
      ps = s; pd = d; n++;
      @(negedge clk);
    end
    kick = 0;
    check(got_done && !busy_at_done, "R6 done with busy low", busy_at_done, 0);
    check(busy_n == total, "R6 busy length", busy_n, total);
    check(rises == 9 && falls == 9, "R3 clock count", rises, 9);
    check(bad_low == 0, "R3 low width", bad_low, 0);
    check(bad_high == 0, "R3 high width", bad_high, 0);
    check(first_high == es + ed, "R2 start setup+hold", first_high, es + ed);
    check(hold1 == ed, "R2 start hold", hold1, ed);
    check(sdalow_scllow == 1 && lowchg == 1, "R4 SDA release", sdalow_scllow, 1);
    check(sfall == 2 && srise == 1, "R5 start/stop edges", sfall*10 + srise, 21);
    check(tail_high == eh + es, "R5 restart setup", tail_high, eh + es);
    check(mid == ed + es, "R5 restart hold + stop setup", mid, ed + es);
    check(free_n == ef, "R6 bus free", free_n, ef);
    check(same_chg == 0, "R9 no dual change", same_chg, 0);
    @(negedge clk);
    check(!done, "R6 done single", done, 0);
    repeat (4) @(negedge clk);
    check(!busy && !scl_oe && !sda_oe, "R7 idle after done", busy, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!scl_oe && !sda_oe && !busy && !done, "R1 reset", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy && !done, "R1 idle", scl_oe, 0);
    run_seq(2, 1, 1, 1, 1, 0);
    // R8 zero counts act as one cycle
    run_seq(2, 0, 0, 0, 0, 0);
    // R7 kick pulses during a long sequence
    run_seq(20, 15, 12, 9, 30, 1);
    for (int i = 0; i < 6; i++)
      run_seq(2 + $urandom_range(0, 10), $urandom_range(0, 10), $urandom_range(0, 10),
              $urandom_range(0, 10), $urandom_range(0, 10), i[0]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule